// File: doc/BRIEF.md
# Host Command Mailbox

The mailbox decouples a host that issues graphics commands from the processor that executes them. The host pushes 32-bit command words into a 16-entry queue and is held off while the queue is full. The processor pops words in order and is held off while the queue is empty. Commands are framed as packets. Each packet starts with a header word that gives an opcode, a flag saying whether the host expects a reply, and the number of payload words that follow.

For a command that expects a reply, the processor fills a small reply buffer and then signals that the command is done. The mailbox latches the reply length and raises a host interrupt. The interrupt stays up until the host acknowledges it by reading the length register. Commands without a reply raise nothing, so the host can go on issuing work while the processor runs.

A separate urgent line lets the host abandon the command in progress. The mailbox then notifies the processor and resets the shared reply state. It also discards every payload word of the current packet that the processor has not yet read, including words that arrive later. Each piece of shared state has exactly one writer: the reply length and interrupt are set only by processor events, and the host can only acknowledge.

Top module: `cmd_mailbox`

## Requirements
- R1: `h_cmd_ready` is low exactly while the queue holds DEPTH (16) words; a push offered while it is low is dropped.
- R2: `p_cmd_valid` is low while the queue is empty, and a pop requested while it is low removes nothing.
- R3: Words leave the queue in the order they were accepted, and an accepted word is visible at `p_cmd_data` in the cycle after the push edge if the queue was empty.
- R4: Header layout: bits [31:24] opcode, bit [23] reply-required, bits [7:0] payload word count. `p_cmd_is_hdr` is high when the next word popped is a header.
- R5: Reply words written by the processor are stored at indices 0, 1, 2, … counted from the last header pop. Writes beyond RPL_DEPTH (8) are dropped. The host reads any entry combinationally through `h_rpl_addr`.
- R6: `p_done` for a packet whose reply bit is set makes `h_irq` high and `h_rpl_len` equal to the number of stored reply words from the next cycle. `h_irq` then holds until an `h_len_rd` pulse.
- R7: `p_done` for a packet whose reply bit is clear leaves `h_irq` low and `h_rpl_len` unchanged.
- R8: An `h_urgent` pulse produces a one-cycle `p_abort` in the next cycle. It clears `h_irq`, `h_rpl_len` and the reply write index. A pop requested in the same cycle is ignored.
- R9: After an urgent pulse, the unread payload words of the current packet are discarded one per cycle, including words pushed afterwards. `p_cmd_valid` stays low until they are gone, and the next packet's header is then presented.
- R10: `h_rpl_len` changes only on a processor `p_done` or an urgent pulse; an `h_len_rd` pulse leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_cmd_valid | input | 1 | Host offers a command word |
| h_cmd_data | input | 32 | Command word from host |
| h_cmd_ready | output | 1 | Queue can accept a word |
| h_urgent | input | 1 | Urgent abort pulse |
| h_rpl_addr | input | $clog2(RPL_DEPTH) | Reply buffer read index |
| h_rpl_data | output | 32 | Reply word at the read index |
| h_rpl_len | output | $clog2(RPL_DEPTH+1) | Latched reply length |
| h_len_rd | input | 1 | Host reads the length register (acknowledge) |
| h_irq | output | 1 | Completion interrupt |
| p_cmd_valid | output | 1 | A word is available to the processor |
| p_cmd_data | output | 32 | Word at the queue head |
| p_cmd_is_hdr | output | 1 | Head word is a packet header |
| p_cmd_pop | input | 1 | Processor consumes the head word |
| p_rpl_we | input | 1 | Processor writes a reply word |
| p_rpl_data | input | 32 | Reply word |
| p_done | input | 1 | Processor finished the current command |
| p_abort | output | 1 | Current command was abandoned |

## Verification
The bench builds the block with its default DEPTH of 16 and RPL_DEPTH of 8. With these values a run of sixteen pushes reaches the full-queue stall, and ten reply writes run past the reply buffer. An urgent abort is raised in the middle of a five-word packet. Part of the leftover payload is still queued and part arrives later, so both halves of the flush are exercised before the next header appears.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int CMD_W   = 32;
    localparam int CNT_W   = 8;
    localparam int OP_LSB  = 24;
    localparam int RPL_BIT = 23;

    typedef struct packed {
        logic [7:0]  opcode;
        logic        need_reply;
        logic [14:0] spare;
        logic [7:0]  words;
    } hdr_t;

    function automatic logic [CNT_W-1:0] hdr_words(input logic [CMD_W-1:0] w);
        hdr_t h;
        h = hdr_t'(w);
        return h.words;
    endfunction

    function automatic logic hdr_reply(input logic [CMD_W-1:0] w);
        hdr_t h;
        h = hdr_t'(w);
        return h.need_reply;
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0] DEPTH_C = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          push_acc;

    assign full     = (count == DEPTH_C);
    assign empty    = (count == '0);
    assign push_acc = push && !full;
    assign rdata    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + AW'(1);
            if (pop)      rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + AW'(1);
            case ({push_acc, pop})
                2'b10:   count <= count + (AW+1)'(1);
                2'b01:   count <= count - (AW+1)'(1);
                default: count <= count;
            endcase
        end
    end

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);
    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !full) |=> (count == $past(count) + (AW+1)'(1)));
endmodule

// File: rtl/mbx_pkt_track.sv
module mbx_pkt_track
    import mbx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             urg,
    input  logic             pop_req,
    input  logic [CMD_W-1:0] head,
    input  logic             fifo_empty,
    output logic             fifo_pop,
    output logic             cmd_valid,
    output logic             is_hdr,
    output logic             hdr_pop,
    output logic             cur_reply
);
    logic [CNT_W-1:0] rem;
    logic [CNT_W:0]   drop;
    logic             pop_eff, drop_pop;

    assign cmd_valid = !fifo_empty && (drop == '0);
    assign pop_eff   = pop_req && cmd_valid && !urg;
    assign drop_pop  = (drop != '0) && !fifo_empty;
    assign fifo_pop  = pop_eff || drop_pop;
    assign is_hdr    = (rem == '0);
    assign hdr_pop   = pop_eff && is_hdr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem       <= '0;
            drop      <= '0;
            cur_reply <= 1'b0;
        end else if (urg) begin
            drop      <= drop - {{CNT_W{1'b0}}, drop_pop} + {1'b0, rem};
            rem       <= '0;
            cur_reply <= 1'b0;
        end else begin
            if (drop_pop) drop <= drop - (CNT_W+1)'(1);
            if (pop_eff) begin
                if (is_hdr) begin
                    rem       <= hdr_words(head);
                    cur_reply <= hdr_reply(head);
                end else begin
                    rem <= rem - CNT_W'(1);
                end
            end
        end
    end

    // R8
    abort_clr_chk: assert property (@(posedge clk) disable iff (rst)
        urg |=> (rem == '0));
    // R9
    flush_step_chk: assert property (@(posedge clk) disable iff (rst)
        ((drop != '0) && !fifo_empty && !urg) |=> (drop == $past(drop) - (CNT_W+1)'(1)));
endmodule

// File: rtl/mbx_reply.sv
module mbx_reply #(
    parameter int W  = 32,
    parameter int RD = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     urg,
    input  logic                     hdr_pop,
    input  logic                     we,
    input  logic [W-1:0]             wdata,
    input  logic                     done,
    input  logic                     cur_reply,
    input  logic                     len_rd,
    input  logic [$clog2(RD)-1:0]    rd_addr,
    output logic [W-1:0]             rd_data,
    output logic [$clog2(RD+1)-1:0]  len,
    output logic                     irq
);
    localparam int LW = $clog2(RD + 1);
    localparam logic [LW-1:0] RD_C = LW'(RD);

    logic [W-1:0]  store [RD];
    logic [LW-1:0] wcount;
    logic          wr_ok;

    assign wr_ok   = we && !urg && !hdr_pop && (wcount < RD_C);
    assign rd_data = store[rd_addr];

    for (genvar i = 0; i < RD; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                               store[i] <= '0;
            else if (wr_ok && wcount == LW'(i))    store[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || urg) begin
            wcount <= '0;
            len    <= '0;
            irq    <= 1'b0;
        end else begin
            if (hdr_pop)    wcount <= '0;
            else if (wr_ok) wcount <= wcount + LW'(1);
            if (done && cur_reply) begin
                len <= wcount;
                irq <= 1'b1;
            end else if (len_rd) begin
                irq <= 1'b0;
            end
        end
    end

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !len_rd && !urg) |=> irq);
    // R10
    len_owner_chk: assert property (@(posedge clk) disable iff (rst)
        (!done && !urg) |=> $stable(len));
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int RPL_DEPTH = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           h_cmd_valid,
    input  logic [31:0]                    h_cmd_data,
    output logic                           h_cmd_ready,
    input  logic                           h_urgent,
    input  logic [$clog2(RPL_DEPTH)-1:0]   h_rpl_addr,
    output logic [31:0]                    h_rpl_data,
    output logic [$clog2(RPL_DEPTH+1)-1:0] h_rpl_len,
    input  logic                           h_len_rd,
    output logic                           h_irq,
    output logic                           p_cmd_valid,
    output logic [31:0]                    p_cmd_data,
    output logic                           p_cmd_is_hdr,
    input  logic                           p_cmd_pop,
    input  logic                           p_rpl_we,
    input  logic [31:0]                    p_rpl_data,
    input  logic                           p_done,
    output logic                           p_abort
);
    logic fifo_pop, fifo_full, fifo_empty, hdr_pop, cur_reply;

    assign h_cmd_ready = !fifo_full;

    mbx_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst),
        .push(h_cmd_valid), .wdata(h_cmd_data),
        .pop(fifo_pop), .rdata(p_cmd_data),
        .full(fifo_full), .empty(fifo_empty)
    );

    mbx_pkt_track u_track (
        .clk(clk), .rst(rst), .urg(h_urgent),
        .pop_req(p_cmd_pop), .head(p_cmd_data), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .cmd_valid(p_cmd_valid), .is_hdr(p_cmd_is_hdr),
        .hdr_pop(hdr_pop), .cur_reply(cur_reply)
    );

    mbx_reply #(.W(CMD_W), .RD(RPL_DEPTH)) u_reply (
        .clk(clk), .rst(rst), .urg(h_urgent), .hdr_pop(hdr_pop),
        .we(p_rpl_we), .wdata(p_rpl_data), .done(p_done),
        .cur_reply(cur_reply), .len_rd(h_len_rd), .rd_addr(h_rpl_addr),
        .rd_data(h_rpl_data), .len(h_rpl_len), .irq(h_irq)
    );

    always_ff @(posedge clk) begin
        if (rst) p_abort <= 1'b0;
        else     p_abort <= h_urgent;
    end

    // R8
    abort_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        h_urgent |=> p_abort);
endmodule

// File: tb/tb_cmd_mailbox.sv
module tb_cmd_mailbox;
    localparam int DEPTH = 16;
    localparam int RD    = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_cmd_valid = 0, h_urgent = 0, h_len_rd = 0;
    logic [31:0] h_cmd_data = '0;
    logic [2:0]  h_rpl_addr = '0;
    logic        p_cmd_pop = 0, p_rpl_we = 0, p_done = 0;
    logic [31:0] p_rpl_data = '0;
    logic        h_cmd_ready, h_irq, p_cmd_valid, p_cmd_is_hdr, p_abort;
    logic [31:0] h_rpl_data, p_cmd_data;
    logic [3:0]  h_rpl_len;

    always #4 clk = ~clk;

    cmd_mailbox #(.DEPTH(DEPTH), .RPL_DEPTH(RD)) dut (.*);

    int checks = 0, errors = 0, cycles = 0;
    bit finished = 0;

    // behavioural reference model
    int unsigned q[$];
    int m_rem = 0, m_drop = 0, m_wc = 0, m_len = 0;
    bit m_cur = 0, m_irq = 0, m_abort = 0;
    int unsigned m_buf [RD];

    always @(posedge clk) begin
        if (rst) begin
            q.delete(); m_rem = 0; m_drop = 0; m_wc = 0; m_len = 0;
            m_cur = 0; m_irq = 0; m_abort = 0;
            foreach (m_buf[i]) m_buf[i] = 0;
        end else begin
            bit valid, pe, dp, hp, pu;
            int unsigned head;
            valid = (q.size() > 0) && (m_drop == 0);
            pe = p_cmd_pop && valid && !h_urgent;
            dp = (m_drop != 0) && (q.size() > 0);
            hp = pe && (m_rem == 0);
            pu = h_cmd_valid && (q.size() < DEPTH);
            head = (q.size() > 0) ? q[0] : 0;
            if (h_urgent) begin
                m_wc = 0; m_len = 0; m_irq = 0;
                m_drop = m_drop - int'(dp) + m_rem; m_rem = 0; m_cur = 0;
            end else begin
                if (p_done && m_cur) begin m_len = m_wc; m_irq = 1; end
                else if (h_len_rd) m_irq = 0;
                if (hp) m_wc = 0;
                else if (p_rpl_we && m_wc < RD) begin m_buf[m_wc] = p_rpl_data; m_wc++; end
                if (dp) m_drop--;
                if (pe) begin
                    if (m_rem == 0) begin m_rem = int'(head[7:0]); m_cur = head[23]; end
                    else m_rem--;
                end
            end
            if (pe || dp) void'(q.pop_front());
            if (pu) q.push_back(h_cmd_data);
            m_abort = h_urgent;
        end
    end

    task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            bit mv;
            mv = (q.size() > 0) && (m_drop == 0);
            chk(h_cmd_ready == (q.size() < DEPTH), "R1 ready", h_cmd_ready, q.size() < DEPTH);
            chk(p_cmd_valid == mv, "R2 valid", p_cmd_valid, mv);
            if (mv) chk(p_cmd_data == q[0], "R3 data", p_cmd_data, q[0]);
            chk(p_cmd_is_hdr == (m_rem == 0), "R4 is_hdr", p_cmd_is_hdr, m_rem == 0);
            chk(h_rpl_data == m_buf[h_rpl_addr], "R5 reply data", h_rpl_data, m_buf[h_rpl_addr]);
            chk(h_rpl_len == 4'(m_len), "R10 len", h_rpl_len, m_len);
            chk(h_irq == m_irq, "R6 irq", h_irq, m_irq);
            chk(p_abort == m_abort, "R8 abort", p_abort, m_abort);
        end
    end

    task automatic tick(); @(negedge clk); #1; endtask
    task automatic push_w(input logic [31:0] d);
        h_cmd_valid = 1; h_cmd_data = d; tick(); h_cmd_valid = 0;
    endtask
    task automatic pop_w(); p_cmd_pop = 1; tick(); p_cmd_pop = 0; endtask
    task automatic wr_rpl(input logic [31:0] d);
        p_rpl_we = 1; p_rpl_data = d; tick(); p_rpl_we = 0;
    endtask
    task automatic done_w(); p_done = 1; tick(); p_done = 0; endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            summary();
        end
    end

    initial begin
        repeat (3) tick();
        rst = 0;
        tick();
        // reset state
        chk(h_cmd_ready == 1, "R1 reset ready", h_cmd_ready, 1);
        chk(p_cmd_valid == 0, "R2 reset valid", p_cmd_valid, 0);
        chk(h_irq == 0 && h_rpl_len == 0, "R6 reset irq/len", {h_irq, h_rpl_len}, 0);

        // reply command: 2 payload words, 2 reply words
        push_w(32'h1180_0002); push_w(32'hD000_0001); push_w(32'hD000_0002);
        chk(p_cmd_is_hdr == 1, "R4 header flagged", p_cmd_is_hdr, 1);
        pop_w();
        chk(p_cmd_is_hdr == 0, "R4 payload not header", p_cmd_is_hdr, 0);
        pop_w(); pop_w();
        chk(p_cmd_valid == 0, "R2 empty after packet", p_cmd_valid, 0);
        pop_w();
        wr_rpl(32'hBEEF_0000); wr_rpl(32'hBEEF_0001);
        chk(h_irq == 0, "R6 no irq before done", h_irq, 0);
        done_w();
        chk(h_irq == 1, "R6 irq after done", h_irq, 1);
        chk(h_rpl_len == 2, "R6 reply length", h_rpl_len, 2);
        h_rpl_addr = 3'd1; #1;
        chk(h_rpl_data == 32'hBEEF_0001, "R5 reply word 1", h_rpl_data, 32'hBEEF_0001);
        repeat (3) tick();
        chk(h_irq == 1, "R6 irq held", h_irq, 1);
        h_len_rd = 1; tick(); h_len_rd = 0;
        chk(h_irq == 0, "R6 irq cleared by length read", h_irq, 0);
        chk(h_rpl_len == 2, "R10 length kept after host read", h_rpl_len, 2);

        // no-reply command
        push_w(32'h4400_0001); push_w(32'hC000_0000);
        pop_w(); pop_w(); done_w();
        chk(h_irq == 0, "R7 no irq without reply", h_irq, 0);
        chk(h_rpl_len == 2, "R7 length unchanged", h_rpl_len, 2);

        // fill the queue past capacity
        for (int i = 0; i < DEPTH + 1; i++) push_w(32'h3000_0000 | (i << 8));
        chk(h_cmd_ready == 0, "R1 full stalls host", h_cmd_ready, 0);
        for (int i = 0; i < DEPTH; i++) begin
            chk(p_cmd_data == (32'h3000_0000 | (i << 8)), "R3 order", p_cmd_data, 32'h3000_0000 | (i << 8));
            pop_w();
        end
        chk(p_cmd_valid == 0, "R1 extra push dropped", p_cmd_valid, 0);

        // urgent abort mid packet
        push_w(32'h0500_0005); push_w(32'hA000_0001); push_w(32'hA000_0002); push_w(32'hA000_0003);
        pop_w(); pop_w();
        h_urgent = 1; p_cmd_pop = 1; tick(); h_urgent = 0; p_cmd_pop = 0;
        chk(p_abort == 1, "R8 abort pulse", p_abort, 1);
        chk(p_cmd_valid == 0, "R9 valid low while flushing", p_cmd_valid, 0);
        push_w(32'hA000_0004); push_w(32'hA000_0005); push_w(32'h2200_0000);
        chk(p_abort == 0, "R8 abort one cycle", p_abort, 0);
        repeat (4) tick();
        chk(p_cmd_valid == 1 && p_cmd_data == 32'h2200_0000, "R9 next header after flush",
            p_cmd_data, 32'h2200_0000);
        chk(p_cmd_is_hdr == 1, "R9 header flag after flush", p_cmd_is_hdr, 1);
        pop_w();

        // reply overflow then urgent clear
        push_w(32'h5580_0000); pop_w();
        for (int i = 0; i < 10; i++) wr_rpl(32'hF000_0000 + i);
        done_w();
        chk(h_rpl_len == RD, "R5 writes past buffer dropped", h_rpl_len, RD);
        h_rpl_addr = 3'd7; #1;
        chk(h_rpl_data == 32'hF000_0007, "R5 last stored word", h_rpl_data, 32'hF000_0007);
        h_urgent = 1; tick(); h_urgent = 0;
        chk(h_irq == 0 && h_rpl_len == 0, "R8 urgent clears reply state", {h_irq, h_rpl_len}, 0);
        repeat (3) tick();
        summary();
    end
endmodule